// File: doc/BRIEF.md
# Atomic halfword swap unit

This unit carries out one already-decoded atomic swap on a 16-bit memory location. It takes the operand fields of the operation (the store register's low half, the destination and base register numbers, the base register value, the stack pointer, the two ordering bits and the current exception level). It issues a locked read of the old halfword and then a write of the new halfword to the same address. The old value is handed back, zero-extended to 32 bits, on a write-back port.

The ordering flags, the tag-check flag and the privilege flag travel with both memory requests. They are derived from the opcode bits and the register numbers. Register number 31 has two meanings. As the base it selects the stack pointer, which must then be 16-byte aligned. As the destination it names the zero register, which discards the result and also suppresses acquire ordering.

When the atomic feature is disabled, the operation ends in an undefined-instruction flag and makes no memory access. A misaligned stack-pointer base ends in an alignment flag and likewise makes no access.

Top module: `hswap_unit`

## Requirements
- R1: After reset, and between operations, `op_ready` is 1 and `mem_req_valid`, `mem_req_lock`, `wb_valid`, `flt_undef` and `flt_align` are 0.
- R2: An accepted operation first issues a read request (`mem_req_write`=0), then a write request (`mem_req_write`=1) to the same address carrying `op_store_hw`. `mem_req_lock` stays 1 from the read request until the cycle in which the write response is taken.
- R3: In the cycle after the write response is taken, `wb_valid` is 1 for one cycle, `wb_idx` equals the destination number, and `wb_data` is the halfword returned by the read, zero-extended to 32 bits.
- R4: `mem_req_acquire` is 1 only when the acquire opcode bit is 1 and the destination number is not 31.
- R5: `mem_req_release` equals the release opcode bit, whatever the register numbers are.
- R6: A base number of 31 puts `op_sp` on `mem_req_addr` with `mem_req_tagchk`=0. Any other base number puts `op_base` on the address with `mem_req_tagchk`=1. No alignment is demanded of a general-register base.
- R7: `mem_req_priv` is 1 exactly when `op_el` is not 0.
- R8: With `feat_atomic_en`=0, an accepted operation raises `flt_undef` for one cycle in the cycle after acceptance. It makes no memory request and no write-back. This fault takes precedence over the alignment fault.
- R9: With the feature enabled, a base number of 31 and `op_sp[3:0]` not zero, `flt_align` is raised for one cycle in the cycle after acceptance. There is no memory request and no write-back.
- R10: A destination number of 31 still performs both memory accesses, but `wb_valid` stays 0.
- R11: A request that is not yet accepted (`mem_req_ready`=0) stays valid, with unchanged address and write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation taken when op_valid is 1 |
| feat_atomic_en | input | 1 | Atomic-operation feature enabled |
| op_acq_bit | input | 1 | Acquire opcode bit |
| op_rel_bit | input | 1 | Release opcode bit |
| op_rt | input | 5 | Destination register number |
| op_rn | input | 5 | Base register number |
| op_store_hw | input | 16 | Low half of the store register |
| op_base | input | 64 | General base register value |
| op_sp | input | 64 | Stack pointer value |
| op_el | input | 2 | Current exception level |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | 64 | Byte address |
| mem_req_wdata | output | 16 | Write halfword |
| mem_req_lock | output | 1 | Bus held for the indivisible pair |
| mem_req_acquire | output | 1 | Acquire ordering attribute |
| mem_req_release | output | 1 | Release ordering attribute |
| mem_req_tagchk | output | 1 | Access is tag-checked |
| mem_req_priv | output | 1 | Access is privileged |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_rdata | input | 16 | Read halfword |
| wb_valid | output | 1 | Register write-back valid |
| wb_idx | output | 5 | Write-back register number |
| wb_data | output | 32 | Write-back value |
| flt_undef | output | 1 | Undefined-instruction flag |
| flt_align | output | 1 | Stack alignment fault flag |

## Verification
The bench builds the unit with its default parameters: 64-bit addresses, 16-bit halfwords, 32-bit registers, 5-bit register numbers and a 16-byte stack alignment. The full-width addresses let random base values exercise the upper address bits. With 5-bit numbers, the value 31 is reachable both by a biased random draw and by directed cases, so the zero-register and stack-pointer paths are hit often. Random stalls on both the request and the response side test the lock window and the request hold.

// File: rtl/hswap_pkg.sv
package hswap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_RSP,
    ST_WR_REQ,
    ST_WR_RSP,
    ST_WBACK,
    ST_FAULT
  } hs_state_e;

  typedef struct packed {
    logic acquire;
    logic release_o;
    logic tagchk;
    logic priv;
  } hs_attr_t;

endpackage

// File: rtl/hswap_attr.sv
module hswap_attr
  import hswap_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int IDX_W      = 5,
  parameter int EL_W       = 2,
  parameter int ALIGN_LOG2 = 4
) (
  input  logic              acq_bit,
  input  logic              rel_bit,
  input  logic [IDX_W-1:0]  rt_idx,
  input  logic [IDX_W-1:0]  rn_idx,
  input  logic [ADDR_W-1:0] gpr_base,
  input  logic [ADDR_W-1:0] sp_base,
  input  logic [EL_W-1:0]   cur_el,
  output hs_attr_t          attr,
  output logic [ADDR_W-1:0] addr,
  output logic              sp_misaligned
);
  localparam logic [IDX_W-1:0] ZR_IDX = '1;

  logic use_sp;

  always_comb begin
    use_sp         = (rn_idx == ZR_IDX);
    addr           = use_sp ? sp_base : gpr_base;
    sp_misaligned  = use_sp && (sp_base[ALIGN_LOG2-1:0] != '0);
    attr.acquire   = acq_bit && (rt_idx != ZR_IDX);
    attr.release_o = rel_bit;
    attr.tagchk    = !use_sp;
    attr.priv      = (cur_el != '0);
  end

  // R4: the zero-register destination never carries acquire
  always_comb begin
    p_acq_zr_r4: assert (!(attr.acquire && (rt_idx == ZR_IDX)));
  end

endmodule

// File: rtl/hswap_seq.sv
module hswap_seq
  import hswap_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 5,
  parameter int HW_W   = 16,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic              feat_en,
  input  hs_attr_t          attr_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              misaligned,
  input  logic [IDX_W-1:0]  rt_idx,
  input  logic [HW_W-1:0]   store_hw,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [HW_W-1:0]   mem_req_wdata,
  output logic              mem_req_lock,
  output hs_attr_t          mem_req_attr,
  input  logic              mem_rsp_valid,
  input  logic [HW_W-1:0]   mem_rsp_rdata,
  output logic              wb_valid,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [REG_W-1:0]  wb_data,
  output logic              flt_undef,
  output logic              flt_align
);
  localparam logic [IDX_W-1:0] ZR_IDX = '1;
  localparam int PAD_W = REG_W - HW_W;

  hs_state_e         state_q;
  hs_attr_t          attr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  rt_q;
  logic [HW_W-1:0]   wdata_q;
  logic [HW_W-1:0]   old_q;
  logic              undef_q;
  logic              align_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      attr_q  <= '0;
      addr_q  <= '0;
      rt_q    <= '0;
      wdata_q <= '0;
      old_q   <= '0;
      undef_q <= 1'b0;
      align_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (op_valid) begin
          attr_q  <= attr_in;
          addr_q  <= addr_in;
          rt_q    <= rt_idx;
          wdata_q <= store_hw;
          if (!feat_en) begin
            undef_q <= 1'b1;
            state_q <= ST_FAULT;
          end else if (misaligned) begin
            align_q <= 1'b1;
            state_q <= ST_FAULT;
          end else begin
            state_q <= ST_RD_REQ;
          end
        end
        ST_FAULT: begin
          undef_q <= 1'b0;
          align_q <= 1'b0;
          state_q <= ST_IDLE;
        end
        ST_RD_REQ: if (mem_req_ready) state_q <= ST_RD_RSP;
        ST_RD_RSP: if (mem_rsp_valid) begin
          old_q   <= mem_rsp_rdata;
          state_q <= ST_WR_REQ;
        end
        ST_WR_REQ: if (mem_req_ready) state_q <= ST_WR_RSP;
        ST_WR_RSP: if (mem_rsp_valid) state_q <= ST_WBACK;
        ST_WBACK:  state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    op_ready      = (state_q == ST_IDLE);
    mem_req_valid = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
    mem_req_write = (state_q == ST_WR_REQ);
    mem_req_lock  = (state_q == ST_RD_REQ) || (state_q == ST_RD_RSP) ||
                    (state_q == ST_WR_REQ) || (state_q == ST_WR_RSP);
    mem_req_addr  = addr_q;
    mem_req_wdata = wdata_q;
    mem_req_attr  = attr_q;
    wb_valid      = (state_q == ST_WBACK) && (rt_q != ZR_IDX);
    wb_idx        = rt_q;
    wb_data       = {{PAD_W{1'b0}}, old_q};
    flt_undef     = undef_q;
    flt_align     = align_q;
  end

  // R2: a write request only ever goes out under the lock
  p_wr_locked_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_write) |-> mem_req_lock);

  // R2: the lock is released only after a response was taken
  p_lock_release_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_req_lock) |-> $past(mem_rsp_valid));

  // R11: a stalled request holds its address and data
  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata)));

  // R3: upper write-back bits are zero
  p_wb_zext_r3: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (wb_data[REG_W-1:HW_W] == '0));

  // R10: no write-back reaches the zero register
  p_no_zr_wb_r10: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (wb_idx != ZR_IDX));

  // R8: an undefined operation touches neither memory nor registers
  p_undef_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    flt_undef |-> (!mem_req_valid && !wb_valid && !mem_req_lock));

  // R9: the two fault flags never coincide
  p_one_fault_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flt_undef, flt_align}));

endmodule

// File: rtl/hswap_unit.sv
module hswap_unit
  import hswap_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int IDX_W      = 5,
  parameter int HW_W       = 16,
  parameter int REG_W      = 32,
  parameter int EL_W       = 2,
  parameter int ALIGN_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic              feat_atomic_en,
  input  logic              op_acq_bit,
  input  logic              op_rel_bit,
  input  logic [IDX_W-1:0]  op_rt,
  input  logic [IDX_W-1:0]  op_rn,
  input  logic [HW_W-1:0]   op_store_hw,
  input  logic [ADDR_W-1:0] op_base,
  input  logic [ADDR_W-1:0] op_sp,
  input  logic [EL_W-1:0]   op_el,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [HW_W-1:0]   mem_req_wdata,
  output logic              mem_req_lock,
  output logic              mem_req_acquire,
  output logic              mem_req_release,
  output logic              mem_req_tagchk,
  output logic              mem_req_priv,
  input  logic              mem_rsp_valid,
  input  logic [HW_W-1:0]   mem_rsp_rdata,
  output logic              wb_valid,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [REG_W-1:0]  wb_data,
  output logic              flt_undef,
  output logic              flt_align
);
  hs_attr_t          attr_c;
  hs_attr_t          attr_req;
  logic [ADDR_W-1:0] addr_c;
  logic              misal_c;

  hswap_attr #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .EL_W(EL_W), .ALIGN_LOG2(ALIGN_LOG2)
  ) u_attr (
    .acq_bit      (op_acq_bit),
    .rel_bit      (op_rel_bit),
    .rt_idx       (op_rt),
    .rn_idx       (op_rn),
    .gpr_base     (op_base),
    .sp_base      (op_sp),
    .cur_el       (op_el),
    .attr         (attr_c),
    .addr         (addr_c),
    .sp_misaligned(misal_c)
  );

  hswap_seq #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .HW_W(HW_W), .REG_W(REG_W)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .op_valid     (op_valid),
    .op_ready     (op_ready),
    .feat_en      (feat_atomic_en),
    .attr_in      (attr_c),
    .addr_in      (addr_c),
    .misaligned   (misal_c),
    .rt_idx       (op_rt),
    .store_hw     (op_store_hw),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write),
    .mem_req_addr (mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_req_lock (mem_req_lock),
    .mem_req_attr (attr_req),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata),
    .wb_valid     (wb_valid),
    .wb_idx       (wb_idx),
    .wb_data      (wb_data),
    .flt_undef    (flt_undef),
    .flt_align    (flt_align)
  );

  assign mem_req_acquire = attr_req.acquire;
  assign mem_req_release = attr_req.release_o;
  assign mem_req_tagchk  = attr_req.tagchk;
  assign mem_req_priv    = attr_req.priv;

endmodule

// File: tb/hswap_unit_test.sv
`timescale 1ns/1ps
module hswap_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic        feat_atomic_en = 1'b1;
  logic        op_acq_bit = 1'b0;
  logic        op_rel_bit = 1'b0;
  logic [4:0]  op_rt = '0;
  logic [4:0]  op_rn = '0;
  logic [15:0] op_store_hw = '0;
  logic [63:0] op_base = '0;
  logic [63:0] op_sp = '0;
  logic [1:0]  op_el = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_write;
  logic [63:0] mem_req_addr;
  logic [15:0] mem_req_wdata;
  logic        mem_req_lock;
  logic        mem_req_acquire;
  logic        mem_req_release;
  logic        mem_req_tagchk;
  logic        mem_req_priv;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_rdata = '0;
  logic        wb_valid;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data;
  logic        flt_undef;
  logic        flt_align;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] bmem [0:255];

  always #2.5 clk = ~clk;

  hswap_unit uut (.*);

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic chk_attr(input bit ea, input bit er, input bit et, input bit ep);
    chk(mem_req_acquire == ea, "R4 acquire", 64'(mem_req_acquire), 64'(ea));
    chk(mem_req_release == er, "R5 release", 64'(mem_req_release), 64'(er));
    chk(mem_req_tagchk == et, "R6 tagchk", 64'(mem_req_tagchk), 64'(et));
    chk(mem_req_priv == ep, "R7 priv", 64'(mem_req_priv), 64'(ep));
  endtask

  task automatic run_op(input bit feat, input bit acqb, input bit relb,
                        input logic [4:0] rt, input logic [4:0] rn,
                        input logic [63:0] gpr, input logic [63:0] sp,
                        input logic [1:0] el, input logic [15:0] shw);
    bit          use_sp = (rn == 5'd31);
    logic [63:0] eaddr  = use_sp ? sp : gpr;
    bit          e_acq  = acqb && (rt != 5'd31);
    bit          e_priv = (el != 2'd0);
    bit          f_u    = !feat;
    bit          f_a    = feat && use_sp && (sp[3:0] != 4'd0);
    logic [7:0]  idx    = eaddr[8:1];
    logic [15:0] old    = bmem[eaddr[8:1]];
    int          phase  = 0;
    int          guard  = 0;
    bit          done   = 0;
    @(negedge clk);
    chk(op_ready == 1'b1, "R1 ready before op", 64'(op_ready), 64'd1);
    feat_atomic_en = feat; op_acq_bit = acqb; op_rel_bit = relb;
    op_rt = rt; op_rn = rn; op_base = gpr; op_sp = sp; op_el = el;
    op_store_hw = shw; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    if (f_u || f_a) begin
      chk(flt_undef == f_u, "R8 undef flag", 64'(flt_undef), 64'(f_u));
      chk(flt_align == f_a, "R9 align flag", 64'(flt_align), 64'(f_a));
      chk(!mem_req_valid && !mem_req_lock, f_u ? "R8 no access" : "R9 no access",
          64'(mem_req_valid), 64'd0);
      chk(!wb_valid, f_u ? "R8 no wb" : "R9 no wb", 64'(wb_valid), 64'd0);
      @(negedge clk);
      chk(!flt_undef && !flt_align && op_ready && !mem_req_valid, "R1 idle after fault",
          64'({flt_undef, flt_align, op_ready}), 64'b001);
      return;
    end
    while (!done && guard < 200) begin
      guard++;
      case (phase)
        0: begin
          chk(mem_req_valid, "R11 read req valid", 64'(mem_req_valid), 64'd1);
          chk(!mem_req_write, "R2 read first", 64'(mem_req_write), 64'd0);
          chk(mem_req_addr == eaddr, "R6 read addr", mem_req_addr, eaddr);
          chk(mem_req_lock, "R2 lock on read", 64'(mem_req_lock), 64'd1);
          chk_attr(e_acq, relb, !use_sp, e_priv);
          mem_req_ready = 1'($urandom % 2);
          if (mem_req_ready) phase = 1;
        end
        1: begin
          mem_req_ready = 1'b0;
          chk(mem_req_lock, "R2 lock in read wait", 64'(mem_req_lock), 64'd1);
          if ($urandom % 2 == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_rdata = old;
            phase = 2;
          end
        end
        2: begin
          mem_rsp_valid = 1'b0;
          mem_rsp_rdata = 16'($urandom);
          chk(mem_req_valid, "R11 write req valid", 64'(mem_req_valid), 64'd1);
          chk(mem_req_write, "R2 write second", 64'(mem_req_write), 64'd1);
          chk(mem_req_addr == eaddr, "R2 same addr", mem_req_addr, eaddr);
          chk(mem_req_wdata == shw, "R2 write data", 64'(mem_req_wdata), 64'(shw));
          chk(mem_req_lock, "R2 lock on write", 64'(mem_req_lock), 64'd1);
          chk_attr(e_acq, relb, !use_sp, e_priv);
          mem_req_ready = 1'($urandom % 2);
          if (mem_req_ready) begin
            bmem[idx] = shw;
            phase = 3;
          end
        end
        3: begin
          mem_req_ready = 1'b0;
          chk(mem_req_lock, "R2 lock in write wait", 64'(mem_req_lock), 64'd1);
          if ($urandom % 2 == 0) begin
            mem_rsp_valid = 1'b1;
            phase = 4;
          end
        end
        4: begin
          mem_rsp_valid = 1'b0;
          chk(!mem_req_lock, "R2 lock released", 64'(mem_req_lock), 64'd0);
          if (rt != 5'd31) begin
            chk(wb_valid, "R3 wb valid", 64'(wb_valid), 64'd1);
            chk(wb_idx == rt, "R3 wb idx", 64'(wb_idx), 64'(rt));
            chk(wb_data == {16'h0, old}, "R3 wb data", 64'(wb_data), 64'({16'h0, old}));
          end else begin
            chk(!wb_valid, "R10 zero reg wb", 64'(wb_valid), 64'd0);
          end
          phase = 5;
        end
        default: begin
          chk(op_ready && !wb_valid && !mem_req_valid, "R1 idle after op",
              64'({op_ready, wb_valid, mem_req_valid}), 64'b100);
          done = 1;
        end
      endcase
      if (!done) @(negedge clk);
    end
    if (!done) chk(1'b0, "R2 sequence stalled", 64'(phase), 64'd5);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) bmem[i] = 16'($urandom);
    repeat (3) @(negedge clk);
    chk(!mem_req_valid && !mem_req_lock && !wb_valid && !flt_undef && !flt_align,
        "R1 outputs in reset", 64'({mem_req_valid, mem_req_lock, wb_valid, flt_undef, flt_align}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(op_ready, "R1 ready after reset", 64'(op_ready), 64'd1);

    // directed corner cases
    run_op(1'b0, 1'b1, 1'b1, 5'd3, 5'd31, 64'h10, 64'h1008, 2'd1, 16'hAAAA); // R8 precedence
    run_op(1'b0, 1'b0, 1'b0, 5'd4, 5'd7, 64'h2000, 64'h0, 2'd0, 16'h1234);    // R8
    run_op(1'b1, 1'b1, 1'b0, 5'd2, 5'd31, 64'h0, 64'hFFFF_0000_0000_0004, 2'd2, 16'h5555); // R9
    run_op(1'b1, 1'b1, 1'b1, 5'd5, 5'd31, 64'h1, 64'h8000_0000_0000_0F30, 2'd3, 16'hBEEF); // R6 sp path
    run_op(1'b1, 1'b0, 1'b0, 5'd9, 5'd12, 64'hDEAD_BEEF_0000_0033, 64'h7, 2'd0, 16'hC0DE); // R6 gpr, no align check
    run_op(1'b1, 1'b1, 1'b0, 5'd31, 5'd1, 64'h40, 64'h0, 2'd1, 16'h0F0F);  // R4, R10
    run_op(1'b1, 1'b0, 1'b1, 5'd31, 5'd31, 64'h0, 64'h100, 2'd0, 16'hF00D); // R5, R10
    run_op(1'b1, 1'b0, 1'b0, 5'd0, 5'd0, 64'h40, 64'h0, 2'd0, 16'h7777);   // reread R3 value written above

    for (int k = 0; k < 300; k++) begin
      logic [4:0]  rt = ($urandom % 4 == 0) ? 5'd31 : 5'($urandom);
      logic [4:0]  rn = ($urandom % 3 == 0) ? 5'd31 : 5'($urandom);
      logic [63:0] sp = {$urandom, $urandom};
      if ($urandom % 4 != 0) sp[3:0] = 4'd0;
      run_op(($urandom % 8) != 0, 1'($urandom), 1'($urandom), rt, rn,
             {$urandom, $urandom}, sp, 2'($urandom), 16'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule